// File: doc/BRIEF.md
# Packet Framing Network Interface

This block sits between a local endpoint and an on-chip packet network. On the transmit side, the endpoint first offers a message command that names a destination node and an 8-bit tag. If the message has a payload, it then streams the payload words. The block places a header word on the network link, passes each payload word through unchanged, and closes the packet with a trailer word. The trailer holds only a checksum, so every packet carries exactly two words of overhead. The payload may have any length, including zero.

On the receive side, the block takes packets from the network link and removes the header and the trailer. It delivers the payload with start and end markers, and it shows the destination and tag of the packet beside the payload. It holds one payload word back so that it can see the trailer before it marks the last word. Because of this, a checksum mismatch is flagged on the same beat as the end marker. Every port pair uses a valid/ready handshake. A beat transfers on a clock edge where valid and ready are both high.

Top module: `pkt_frame_ni`

## Requirements
- R1: The first word of each transmitted packet is the header. The header has the destination in bits [31:24], the tag in bits [23:16] and zero in bits [15:0]. The header is sent while `cmd_valid` is high, and `cmd_ready` follows `net_ready` while the transmitter waits for a command.
- R2: After the header, the payload words leave on `net_data` unchanged and in order, with `net_last` low. A command with `cmd_empty` low takes payload until the word that has `pl_last` high.
- R3: The word after the last payload word is the trailer. The trailer equals the XOR of the header and all payload words of that packet, and `net_last` is high on the trailer only.
- R4: A command with `cmd_empty` high produces a header followed at once by a trailer. That trailer equals the header.
- R5: While the trailer is offered and `net_ready` is low, `net_valid` and `net_last` stay high and `net_data` does not change.
- R6: The receiver does not forward the header word or the trailer word. It shows the header's bits [31:24] on `out_dest` and bits [23:16] on `out_tag` for every payload beat of that packet.
- R7: Received payload words appear on `out_data` in order. `out_sop` is high on the first payload word and `out_eop` is high on the last payload word. The last payload word is the one directly before the word that has `in_last` high.
- R8: `out_err` is high on the beat that has `out_eop` high exactly when the XOR of the received header and payload differs from the received trailer. At all other times `out_err` is low.
- R9: A received packet with no payload, that is a header followed directly by a trailer, produces no beat with `out_valid` high.
- R10: While `out_valid` is high and `out_ready` is low, the receive outputs `out_data`, `out_sop`, `out_eop` and `out_err` do not change, and `in_ready` is low.
- R11: After reset, `net_valid` and `out_valid` are low while no input is offered, and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Message command offered |
| cmd_ready | output | 1 | Command accepted (header sent) |
| cmd_dest | input | 8 | Destination node |
| cmd_tag | input | 8 | Packet tag |
| cmd_empty | input | 1 | Message has no payload |
| pl_valid | input | 1 | Transmit payload word offered |
| pl_ready | output | 1 | Transmit payload word accepted |
| pl_data | input | 32 | Transmit payload word |
| pl_last | input | 1 | Last payload word of the message |
| net_valid | output | 1 | Link word offered |
| net_ready | input | 1 | Link accepts word |
| net_data | output | 32 | Outgoing link word |
| net_last | output | 1 | Outgoing word is the trailer |
| in_valid | input | 1 | Incoming link word offered |
| in_ready | output | 1 | Incoming word accepted |
| in_data | input | 32 | Incoming link word |
| in_last | input | 1 | Incoming word is the trailer |
| out_valid | output | 1 | Received payload word offered |
| out_ready | input | 1 | Sink accepts payload word |
| out_data | output | 32 | Received payload word |
| out_sop | output | 1 | First payload word of the packet |
| out_eop | output | 1 | Last payload word of the packet |
| out_err | output | 1 | Checksum mismatch, valid with out_eop |
| out_dest | output | 8 | Destination of the current packet |
| out_tag | output | 8 | Tag of the current packet |

## Verification
A transmit state that has jumped by mistake shows on the link in the same cycle. The bench would see a payload word where the header should be, a trailer that is missing, or `net_last` high too early. A wrong checksum register shows as a bad trailer value. On the receive side, a stuck hold register or a lost start flag shows on the next payload beat. A checksum that was never cleared at a header makes `out_err` rise falsely on the end beat of the following packet. For this reason, a good packet is always sent after a corrupted one.

// File: rtl/pkt_frame_ni.sv
`timescale 1ns/1ps
module pkt_frame_ni #(
  parameter int W  = 32,
  parameter int AW = 8,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [AW-1:0] cmd_dest,
  input  logic [TW-1:0] cmd_tag,
  input  logic          cmd_empty,
  input  logic          pl_valid,
  output logic          pl_ready,
  input  logic [W-1:0]  pl_data,
  input  logic          pl_last,
  output logic          net_valid,
  input  logic          net_ready,
  output logic [W-1:0]  net_data,
  output logic          net_last,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  input  logic          in_last,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data,
  output logic          out_sop,
  output logic          out_eop,
  output logic          out_err,
  output logic [AW-1:0] out_dest,
  output logic [TW-1:0] out_tag
);
  localparam int PADW = W - AW - TW;

  typedef enum logic [1:0] {TX_HDR, TX_PAY, TX_TRL} tx_st_t;
  tx_st_t       tx_st;
  logic [W-1:0] tx_sum;
  logic [W-1:0] hdr_word;
  logic         net_fire;

  assign hdr_word  = {cmd_dest, cmd_tag, {PADW{1'b0}}};
  assign cmd_ready = (tx_st == TX_HDR) && net_ready;
  assign pl_ready  = (tx_st == TX_PAY) && net_ready;
  assign net_valid = (tx_st == TX_HDR) ? cmd_valid :
                     (tx_st == TX_PAY) ? pl_valid  : 1'b1;
  assign net_data  = (tx_st == TX_HDR) ? hdr_word :
                     (tx_st == TX_PAY) ? pl_data  : tx_sum;
  assign net_last  = (tx_st == TX_TRL);
  assign net_fire  = net_valid && net_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_st  <= TX_HDR;
      tx_sum <= '0;
    end else if (net_fire) begin
      case (tx_st)
        TX_HDR: begin
          tx_sum <= hdr_word;
          tx_st  <= cmd_empty ? TX_TRL : TX_PAY;
        end
        TX_PAY: begin
          tx_sum <= tx_sum ^ pl_data;
          if (pl_last) tx_st <= TX_TRL;
        end
        default: tx_st <= TX_HDR;
      endcase
    end
  end

  logic         rx_body;
  logic         hold_vld;
  logic         hold_sop;
  logic [W-1:0] hold_data;
  logic [W-1:0] rx_sum;
  logic         in_fire;

  assign in_ready  = !rx_body || !hold_vld || out_ready;
  assign in_fire   = in_valid && in_ready;
  assign out_valid = rx_body && hold_vld && in_valid;
  assign out_data  = hold_data;
  assign out_sop   = hold_sop;
  assign out_eop   = in_last;
  assign out_err   = out_valid && in_last && (rx_sum != in_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_body   <= 1'b0;
      hold_vld  <= 1'b0;
      hold_sop  <= 1'b0;
      hold_data <= '0;
      rx_sum    <= '0;
      out_dest  <= '0;
      out_tag   <= '0;
    end else if (in_fire) begin
      if (!rx_body) begin
        rx_body  <= 1'b1;
        rx_sum   <= in_data;
        out_dest <= in_data[W-1 -: AW];
        out_tag  <= in_data[W-AW-1 -: TW];
      end else if (in_last) begin
        rx_body  <= 1'b0;
        hold_vld <= 1'b0;
      end else begin
        hold_vld  <= 1'b1;
        hold_sop  <= !hold_vld;
        hold_data <= in_data;
        rx_sum    <= rx_sum ^ in_data;
      end
    end
  end

  AST_TRL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    net_valid && net_last && !net_ready |=> net_valid && net_last && $stable(net_data)); // R5
  AST_ONE_TX_SINK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_ready, pl_ready})); // R2
  AST_ERR_ON_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> out_valid && out_eop); // R8
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_data) && $stable(out_sop)); // R10
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R10
  AST_DEST_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_sop |-> $stable(out_dest) && $stable(out_tag)); // R6
endmodule

// File: tb/pkt_frame_ni_tb.sv
`timescale 1ns/1ps
module pkt_frame_ni_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, cmd_ready, cmd_empty = 0;
  logic [7:0] cmd_dest = 0, cmd_tag = 0;
  logic pl_valid = 0, pl_ready, pl_last = 0;
  logic [31:0] pl_data = 0;
  logic net_valid, net_ready = 0, net_last;
  logic [31:0] net_data;
  logic in_valid = 0, in_ready, in_last = 0;
  logic [31:0] in_data = 0;
  logic out_valid, out_ready = 0, out_sop, out_eop, out_err;
  logic [31:0] out_data;
  logic [7:0] out_dest, out_tag;
  int nchk = 0, nbad = 0;

  always #2.5 clk = ~clk;

  pkt_frame_ni u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_dest(cmd_dest),
    .cmd_tag(cmd_tag), .cmd_empty(cmd_empty),
    .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_data(pl_data), .pl_last(pl_last),
    .net_valid(net_valid), .net_ready(net_ready), .net_data(net_data), .net_last(net_last),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .out_err(out_err),
    .out_dest(out_dest), .out_tag(out_tag));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pay(input int seed, input int i);
    return 32'h9E37_79B9 * (seed + 1) ^ (i * 32'h0101_0107);
  endfunction

  task automatic test_reset();
    @(negedge clk); #1;
    chk(!net_valid, "R11 net_valid", net_valid, 0);
    chk(!out_valid, "R11 out_valid", out_valid, 0);
    chk(in_ready, "R11 in_ready", in_ready, 1);
  endtask

  task automatic test_tx(input logic [7:0] d, input logic [7:0] t, input int n, input bit stall);
    logic [31:0] hdr, sum;
    hdr = {d, t, 16'h0};
    sum = hdr;
    @(negedge clk);
    cmd_valid = 1; cmd_dest = d; cmd_tag = t; cmd_empty = (n == 0);
    net_ready = 0; #1;
    chk(!cmd_ready, "R1 cmd_ready follows net_ready", cmd_ready, 0);
    net_ready = 1; #1;
    chk(cmd_ready && net_valid && !net_last, "R1 header handshake", {cmd_ready, net_valid, net_last}, 3'b110);
    chk(net_data == hdr, "R1 header word", net_data, hdr);
    @(posedge clk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmd_valid = 0; pl_valid = 1; pl_data = pay(d, i); pl_last = (i == n - 1); #1;
      chk(net_valid && !net_last && net_data == pay(d, i), "R2 payload word", net_data, pay(d, i));
      sum ^= pay(d, i);
      @(posedge clk);
    end
    @(negedge clk);
    cmd_valid = 0; pl_valid = 0; pl_last = 0;
    if (stall) begin
      net_ready = 0;
      @(posedge clk); @(negedge clk); #1;
      chk(net_valid && net_last && net_data == sum, "R5 trailer held", net_data, sum);
      net_ready = 1;
    end
    #1;
    if (n == 0) chk(net_last && net_data == hdr, "R4 empty trailer equals header", net_data, hdr);
    else chk(net_valid && net_last && net_data == sum, "R3 trailer checksum", net_data, sum);
    @(posedge clk);
    @(negedge clk); net_ready = 0; #1;
    chk(!net_valid, "R3 idle after trailer", net_valid, 0);
  endtask

  task automatic test_rx(input logic [7:0] d, input logic [7:0] t, input int n, input bit bad, input bit stall);
    logic [31:0] w [0:17];
    logic [31:0] sum;
    int seen = 0;
    w[0] = {d, t, 16'h5A5A};
    sum = w[0];
    for (int i = 0; i < n; i++) begin w[i+1] = pay(t, i); sum ^= w[i+1]; end
    w[n+1] = bad ? ~sum : sum;
    for (int j = 0; j <= n + 1; j++) begin
      @(negedge clk);
      in_valid = 1; in_data = w[j]; in_last = (j == n + 1); out_ready = 1; #1;
      if (j >= 2) begin
        if (stall && j == n + 1) begin
          out_ready = 0; #1;
          chk(!in_ready, "R10 in_ready low on stall", in_ready, 0);
          @(posedge clk); @(negedge clk); #1;
          chk(out_valid && out_data == w[j-1] && out_eop, "R10 output held", out_data, w[j-1]);
          out_ready = 1; #1;
        end
        seen++;
        chk(out_valid && out_data == w[j-1], "R7 payload order", out_data, w[j-1]);
        chk(out_sop == (j == 2) && out_eop == (j == n + 1), "R7 markers", {out_sop, out_eop}, {j == 2, j == n + 1});
        chk(out_err == (bad && j == n + 1), "R8 checksum flag", out_err, bad && j == n + 1);
        chk(out_dest == d && out_tag == t, "R6 dest/tag", {out_dest, out_tag}, {d, t});
      end else begin
        chk(!out_valid, "R6 header not forwarded", out_valid, 0);
      end
      if (n == 0 && j == 1) chk(!out_valid, "R9 empty packet silent", out_valid, 0);
      @(posedge clk);
    end
    @(negedge clk); in_valid = 0; in_last = 0; #1;
    chk(!out_valid && seen == n, "R6 trailer not forwarded", seen, n);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1;
    test_reset();
    test_tx(8'hA3, 8'h11, 3, 0);
    test_tx(8'h00, 8'hFF, 1, 1);
    test_tx(8'hFF, 8'h42, 0, 1);
    test_tx(8'h5C, 8'h07, 6, 0);
    test_rx(8'h12, 8'h34, 4, 0, 0);
    test_rx(8'h9A, 8'hBC, 3, 1, 0);
    test_rx(8'h77, 8'h01, 2, 0, 1);
    test_rx(8'h01, 8'h02, 0, 0, 0);
    test_rx(8'hEE, 8'hDD, 1, 1, 1);
    test_rx(8'h44, 8'h55, 5, 0, 0);
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule